// File: doc/BRIEF.md
# EDO DRAM Strobe-Cycle Decoder

This block watches the four active-low control strobes of an extended-data-out DRAM (row strobe, column strobe, write enable, output enable) on a fast system clock. It works out which kind of memory cycle the controller has just run and reports it as a three-bit code with a one-cycle valid pulse when the row strobe is released. The cycle kinds are read, early write, late write, read-modify-write, row-only refresh, column-before-row refresh, hidden refresh and self refresh.

In parallel it tracks whether the DRAM's data pins would be driving at each sample. This follows the EDO output rules. Read data stays valid after the column strobe rises. An output-enable pulse during an access blanks the data and restores it. An output-enable toggle, or a write-enable pulse, while the column strobe is high turns the pins off until a later read access. The pins turn off once both strobes have been released. A late write that is tried while output enable is still asserted does not write; the block flags it as a protocol violation.

The block is meant for a protocol checker or a bus monitor placed beside a DRAM controller. The strobes may be asynchronous to the clock as long as each level lasts at least two clock periods. One input register stage samples them.

Top module: `edo_strobe_decoder`

## Requirements
- R1: After reset, and while reset is held, `cyc_valid_o`, `dq_drive_o` and `blocked_write_o` are 0.
- R2: When a row-strobe release is sampled, `cyc_valid_o` is high for exactly one clock cycle, two rising clock edges after the strobe change. `cyc_type_o` carries the code of the finished cycle: 0 read, 1 early write, 2 late write, 3 read-modify-write, 4 row-only refresh, 5 column-before-row refresh, 6 hidden refresh, 7 self refresh.
- R3: A column-strobe assertion while the row strobe is asserted and write enable is high starts a read. The data pins drive while output enable is asserted, and the row period reports code 0. In a page with several column accesses, the last access gives the code.
- R4: A column-strobe assertion with write enable already asserted is an early write (code 1). The data pins stay off whatever output enable does.
- R5: Write enable asserted after the column strobe, with output enable high, is a write. It is code 3 if read data was enabled earlier in that column access, and code 2 otherwise. The data pins stay off for the rest of that column access.
- R6: Write enable asserted after the column strobe while output enable is still asserted writes nothing. `blocked_write_o` pulses for one cycle, the data pins keep driving read data, and the access stays a read (code 0).
- R7: A row period with no column-strobe assertion, and with the column strobe high at the row-strobe assertion, reports code 4.
- R8: Column strobe asserted before the row strobe reports code 5. It reports code 7 when the row strobe was sampled asserted on at least SELF_REF_CYCLES clocks.
- R9: A row strobe re-asserted while the column strobe stays asserted from an earlier read or write access reports code 6. The data pins keep driving until the column strobe is released.
- R10: An output-enable pulse while row and column strobes are asserted turns the data pins off and then back on with no new column access.
- R11: Read data keeps driving after the column strobe is released while the row strobe and output enable stay asserted. Any output-enable change during that column-high time turns the pins off until the next read column access.
- R12: A write-enable pulse while the column strobe is high turns the pins off until the column strobe is asserted with write enable high.
- R13: Once both row and column strobes are sampled high, the data pins are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| cyc_type_o | output | 3 | Code of the cycle just finished |
| cyc_valid_o | output | 1 | One-cycle pulse marking a new `cyc_type_o` |
| dq_drive_o | output | 1 | DRAM data pins would be driving |
| blocked_write_o | output | 1 | One-cycle pulse for a late write blocked by output enable |

## Verification
Every result is due two rising edges after the strobe change that causes it. The first edge loads the sampling register, and the second loads the registered outputs from the detected edge. The bench changes strobes on a falling edge, waits two full clock periods and reads outputs on the following falling edge. It then waits one more period to confirm that the valid and violation pulses have ended. The self-refresh threshold is tested on both sides with row-strobe low times of SELF_REF_CYCLES-1 and SELF_REF_CYCLES samples.

// File: rtl/edo_dec_pkg.sv
package edo_dec_pkg;

  typedef enum logic [2:0] {
    CYC_READ     = 3'd0,
    CYC_EARLY_WR = 3'd1,
    CYC_LATE_WR  = 3'd2,
    CYC_RMW      = 3'd3,
    CYC_RAS_ONLY = 3'd4,
    CYC_CBR      = 3'd5,
    CYC_HIDDEN   = 3'd6,
    CYC_SELF     = 3'd7
  } cyc_e;

  // 1 = strobe asserted (pin low)
  typedef struct packed {
    logic ras;
    logic cas;
    logic we;
    logic oe;
  } strobe_t;

endpackage

// File: rtl/edo_strobe_sampler.sv
module edo_strobe_sampler
  import edo_dec_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    ras_ni,
  input  logic    cas_ni,
  input  logic    we_ni,
  input  logic    oe_ni,
  output strobe_t cur_o,
  output strobe_t prv_o
);

  localparam int unsigned NSTB = $bits(strobe_t);

  logic [NSTB-1:0] pins_n;
  logic [NSTB-1:0] cur_q, prv_q;

  assign pins_n = {ras_ni, cas_ni, we_ni, oe_ni};

  for (genvar g = 0; g < NSTB; g++) begin : g_stb
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cur_q[g] <= 1'b0;
        prv_q[g] <= 1'b0;
      end else begin
        cur_q[g] <= ~pins_n[g];
        prv_q[g] <= cur_q[g];
      end
    end
  end

  assign cur_o = strobe_t'(cur_q);
  assign prv_o = strobe_t'(prv_q);

endmodule

// File: rtl/edo_cycle_class.sv
module edo_cycle_class
  import edo_dec_pkg::*;
#(
  parameter int unsigned SELF_REF_CYCLES = 10000
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  strobe_t cur_i,
  input  strobe_t prv_i,
  output cyc_e    type_o,
  output logic    valid_o,
  output logic    blocked_o
);

  localparam int unsigned CW = $clog2(SELF_REF_CYCLES + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(SELF_REF_CYCLES);

  typedef enum logic [1:0] {REF_NONE, REF_CBR, REF_HID} ref_e;

  logic ras_on, ras_off, cas_on, we_on;
  assign ras_on  =  cur_i.ras & ~prv_i.ras;
  assign ras_off = ~cur_i.ras &  prv_i.ras;
  assign cas_on  =  cur_i.cas & ~prv_i.cas;
  assign we_on   =  cur_i.we  & ~prv_i.we;

  logic [CW-1:0] cnt_q, cnt_d;
  ref_e ref_q, ref_d;
  logic col_q, col_d;    // column access seen this row period
  logic held_q, held_d;  // column strobe held since an access
  logic rd_q, rd_d;      // read data enabled in this column access
  cyc_e acc_q, acc_d;
  cyc_e type_q, type_d;
  logic valid_q, valid_d;
  logic blk_q, blk_d;

  always_comb begin
    cnt_d   = cnt_q;
    ref_d   = ref_q;
    col_d   = col_q;
    held_d  = held_q;
    rd_d    = rd_q;
    acc_d   = acc_q;
    type_d  = type_q;
    valid_d = 1'b0;
    blk_d   = 1'b0;

    if (ras_on) begin
      cnt_d = CW'(1);
      col_d = 1'b0;
      if (prv_i.cas) ref_d = held_q ? REF_HID : REF_CBR;
      else           ref_d = REF_NONE;
    end else if (cur_i.ras && cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + CW'(1);
    end

    if (!cur_i.cas)                held_d = 1'b0;
    else if (cas_on && cur_i.ras)  held_d = 1'b1;

    if (cas_on && cur_i.ras) begin
      col_d = 1'b1;
      acc_d = cur_i.we ? CYC_EARLY_WR : CYC_READ;
      rd_d  = ~cur_i.we & cur_i.oe;
    end else if (cur_i.cas && cur_i.ras) begin
      if (cur_i.oe && prv_i.oe && !cur_i.we) rd_d = 1'b1;
      if (we_on) begin
        if (cur_i.oe) blk_d = 1'b1;
        else          acc_d = rd_q ? CYC_RMW : CYC_LATE_WR;
      end
    end

    if (ras_off) begin
      valid_d = 1'b1;
      unique case (ref_q)
        REF_CBR: type_d = (cnt_q >= CNT_MAX) ? CYC_SELF : CYC_CBR;
        REF_HID: type_d = CYC_HIDDEN;
        default: type_d = col_q ? acc_q : CYC_RAS_ONLY;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ref_q   <= REF_NONE;
      col_q   <= 1'b0;
      held_q  <= 1'b0;
      rd_q    <= 1'b0;
      acc_q   <= CYC_READ;
      type_q  <= CYC_READ;
      valid_q <= 1'b0;
      blk_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      ref_q   <= ref_d;
      col_q   <= col_d;
      held_q  <= held_d;
      rd_q    <= rd_d;
      acc_q   <= acc_d;
      type_q  <= type_d;
      valid_q <= valid_d;
      blk_q   <= blk_d;
    end
  end

  assign type_o    = type_q;
  assign valid_o   = valid_q;
  assign blocked_o = blk_q;

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q); // R2

  AST_CAS_FIRST_IS_REFRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_on && prv_i.cas && !held_q) |=> (ref_q == REF_CBR)); // R8

  AST_BLOCK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_q |=> !blk_q); // R6

endmodule

// File: rtl/edo_dq_track.sv
module edo_dq_track
  import edo_dec_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  strobe_t cur_i,
  input  strobe_t prv_i,
  output logic    drive_o
);

  logic cas_on, we_on, oe_chg, ras_off;
  assign cas_on  = cur_i.cas & ~prv_i.cas;
  assign we_on   = cur_i.we  & ~prv_i.we;
  assign oe_chg  = cur_i.oe  ^  prv_i.oe;
  assign ras_off = ~cur_i.ras & prv_i.ras;

  logic dval_q, dval_d;    // read data latched in output buffer
  logic wehz_q, wehz_d;    // off after write-enable pulse, column high
  logic oehz_q, oehz_d;    // off after output-enable change, column high
  logic lock_q, lock_d;    // off for rest of a written column access
  logic drv_q, drv_d;

  always_comb begin
    dval_d = dval_q;
    wehz_d = wehz_q;
    oehz_d = oehz_q;
    lock_d = lock_q;

    if (cas_on) begin
      dval_d = cur_i.ras & ~cur_i.we;
      oehz_d = 1'b0;
      lock_d = 1'b0;
      if (!cur_i.we) wehz_d = 1'b0;
    end else begin
      if (we_on && !cur_i.cas) wehz_d = 1'b1;
      if (we_on && cur_i.cas && cur_i.ras && !cur_i.oe) lock_d = 1'b1;
      if (oe_chg && !cur_i.cas && cur_i.ras && dval_q) oehz_d = 1'b1;
    end

    if (ras_off) oehz_d = 1'b0;
    if (!cur_i.ras && !cur_i.cas) dval_d = 1'b0;

    drv_d = dval_d & cur_i.oe & ~wehz_d & ~oehz_d & ~lock_d
          & (cur_i.ras | cur_i.cas);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dval_q <= 1'b0;
      wehz_q <= 1'b0;
      oehz_q <= 1'b0;
      lock_q <= 1'b0;
      drv_q  <= 1'b0;
    end else begin
      dval_q <= dval_d;
      wehz_q <= wehz_d;
      oehz_q <= oehz_d;
      lock_q <= lock_d;
      drv_q  <= drv_d;
    end
  end

  assign drive_o = drv_q;

  AST_EARLY_WR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cas_on && cur_i.ras && cur_i.we) |=> !drv_q); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cur_i.ras && !cur_i.cas) |=> !drv_q); // R13

  AST_OE_GATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cur_i.oe |=> !drv_q); // R10

endmodule

// File: rtl/edo_strobe_decoder.sv
module edo_strobe_decoder
  import edo_dec_pkg::*;
#(
  parameter int unsigned SELF_REF_CYCLES = 10000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ras_ni,
  input  logic       cas_ni,
  input  logic       we_ni,
  input  logic       oe_ni,
  output logic [2:0] cyc_type_o,
  output logic       cyc_valid_o,
  output logic       dq_drive_o,
  output logic       blocked_write_o
);

  strobe_t cur, prv;
  cyc_e    cls_type;

  edo_strobe_sampler u_smp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ras_ni (ras_ni),
    .cas_ni (cas_ni),
    .we_ni  (we_ni),
    .oe_ni  (oe_ni),
    .cur_o  (cur),
    .prv_o  (prv)
  );

  edo_cycle_class #(
    .SELF_REF_CYCLES (SELF_REF_CYCLES)
  ) u_cls (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cur_i     (cur),
    .prv_i     (prv),
    .type_o    (cls_type),
    .valid_o   (cyc_valid_o),
    .blocked_o (blocked_write_o)
  );

  edo_dq_track u_dq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cur_i   (cur),
    .prv_i   (prv),
    .drive_o (dq_drive_o)
  );

  assign cyc_type_o = cls_type;

  AST_BLOCK_KEEPS_DQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blocked_write_o |-> dq_drive_o); // R6

  AST_TYPE_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_valid_o |-> !$isunknown(cyc_type_o)); // R2

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (!cyc_valid_o && !dq_drive_o && !blocked_write_o)); // R1

endmodule

// File: tb/edo_strobe_decoder_tb.sv
module edo_strobe_decoder_tb_top;

  localparam int unsigned SELF_N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [2:0] cyc_type;
  logic cyc_valid, dq_drive, blocked;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  edo_strobe_decoder #(.SELF_REF_CYCLES(SELF_N)) dut_i (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .ras_ni          (ras_n),
    .cas_ni          (cas_n),
    .we_ni           (we_n),
    .oe_ni           (oe_n),
    .cyc_type_o      (cyc_type),
    .cyc_valid_o     (cyc_valid),
    .dq_drive_o      (dq_drive),
    .blocked_write_o (blocked)
  );

  task automatic tick(int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  // pin levels, 1 = high (deasserted); outputs due after two rising edges
  task automatic drv(logic r, logic c, logic w, logic o);
    ras_n = r; cas_n = c; we_n = w; oe_n = o;
    tick(2);
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic end_row(logic c, int exp_type, string tag);
    drv(1'b1, c, 1'b1, c);
    chk({tag, " valid"}, int'(cyc_valid), 1);
    chk({tag, " type"}, int'(cyc_type), exp_type);
    tick(1);
    chk("R2 valid single cycle", int'(cyc_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", int'(cyc_valid), 0);
    chk("R1 drive in reset", int'(dq_drive), 0);
    rst_n = 1'b1;
    tick(3);
    chk("R1 valid after reset", int'(cyc_valid), 0);
    chk("R1 drive after reset", int'(dq_drive), 0);
    chk("R1 blocked after reset", int'(blocked), 0);

    // R3 read with EDO hold
    drv(0, 1, 1, 1);
    drv(0, 0, 1, 0);
    chk("R3 read drives", int'(dq_drive), 1);
    drv(0, 1, 1, 0);
    chk("R11 data held after column release", int'(dq_drive), 1);
    end_row(1'b1, 0, "R3 read");
    chk("R13 off after both released", int'(dq_drive), 0);

    // R4 early write
    drv(0, 1, 1, 1);
    drv(0, 1, 0, 1);
    drv(0, 0, 0, 0);
    chk("R4 early write quiet with oe on", int'(dq_drive), 0);
    drv(0, 1, 1, 0);
    chk("R4 early write quiet after column", int'(dq_drive), 0);
    end_row(1'b1, 1, "R4 early write");

    // R5 late write
    drv(0, 1, 1, 1);
    drv(0, 0, 1, 1);
    drv(0, 0, 0, 1);
    chk("R5 late write no violation", int'(blocked), 0);
    drv(0, 0, 0, 0);
    chk("R5 late write stays off", int'(dq_drive), 0);
    drv(0, 1, 1, 1);
    end_row(1'b1, 2, "R5 late write");

    // R5 read-modify-write, R10 oe pulse
    drv(0, 1, 1, 1);
    drv(0, 0, 1, 0);
    chk("R5 rmw read phase", int'(dq_drive), 1);
    drv(0, 0, 1, 1);
    chk("R10 oe pulse off", int'(dq_drive), 0);
    drv(0, 0, 1, 0);
    chk("R10 oe pulse back on", int'(dq_drive), 1);
    drv(0, 0, 1, 1);
    drv(0, 0, 0, 1);
    chk("R5 rmw write phase off", int'(dq_drive), 0);
    drv(0, 1, 1, 1);
    end_row(1'b1, 3, "R5 rmw");

    // R6 blocked late write
    drv(0, 1, 1, 1);
    drv(0, 0, 1, 0);
    ras_n = 0; cas_n = 0; we_n = 0; oe_n = 0;
    tick(2);
    chk("R6 violation pulse", int'(blocked), 1);
    chk("R6 keeps driving", int'(dq_drive), 1);
    tick(1);
    chk("R6 violation single cycle", int'(blocked), 0);
    drv(0, 1, 1, 1);
    end_row(1'b1, 0, "R6 blocked stays read");

    // R7 row-only refresh
    drv(0, 1, 1, 1);
    tick(3);
    end_row(1'b1, 4, "R7 row-only");

    // R8 cbr just below threshold: 2+13 = SELF_N-1 low samples
    drv(1, 0, 1, 1);
    drv(0, 0, 1, 1);
    tick(SELF_N - 3);
    end_row(1'b0, 5, "R8 cbr");
    drv(1, 1, 1, 1);

    // R8 self refresh at threshold: SELF_N low samples
    drv(1, 0, 1, 1);
    drv(0, 0, 1, 1);
    tick(SELF_N - 2);
    end_row(1'b0, 7, "R8 self refresh");
    chk("R8 no drive in refresh", int'(dq_drive), 0);
    drv(1, 1, 1, 1);

    // R9 hidden refresh after read
    drv(0, 1, 1, 1);
    drv(0, 0, 1, 0);
    ras_n = 1;
    tick(2);
    chk("R9 first row read valid", int'(cyc_valid), 1);
    chk("R9 first row read type", int'(cyc_type), 0);
    chk("R9 drive held column low", int'(dq_drive), 1);
    drv(0, 0, 1, 0);
    ras_n = 1;
    tick(2);
    chk("R9 hidden valid", int'(cyc_valid), 1);
    chk("R9 hidden type", int'(cyc_type), 6);
    chk("R9 still driving", int'(dq_drive), 1);
    drv(1, 1, 1, 1);
    chk("R13 off after column release", int'(dq_drive), 0);

    // R11 oe toggle during column-high time
    drv(0, 1, 1, 1);
    drv(0, 0, 1, 0);
    drv(0, 1, 1, 0);
    chk("R11 held before toggle", int'(dq_drive), 1);
    drv(0, 1, 1, 1);
    drv(0, 1, 1, 0);
    chk("R11 stays off after toggle", int'(dq_drive), 0);
    drv(0, 0, 1, 0);
    chk("R11 on at next read", int'(dq_drive), 1);

    // R12 we pulse during column-high time
    drv(0, 1, 1, 0);
    chk("R12 held before pulse", int'(dq_drive), 1);
    drv(0, 1, 0, 0);
    chk("R12 off during pulse", int'(dq_drive), 0);
    drv(0, 1, 1, 0);
    chk("R12 stays off after pulse", int'(dq_drive), 0);
    drv(0, 0, 1, 0);
    chk("R12 on at next read", int'(dq_drive), 1);
    drv(0, 1, 1, 0);
    end_row(1'b1, 0, "R3 page read");
    chk("R13 off at end", int'(dq_drive), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule